// File: doc/BRIEF.md
# LED Fault Status Capture Sequencer

This block gathers the per-channel fault comparator results of a 16-channel constant-current LED sink driver. It stores them in a 16-bit status holder that the serial path can later read. A 2-bit select field chooses the source: open-circuit results, short-circuit results or leakage results, or no capture at all. Each result bit is qualified by that channel's on-off bit. A device-wide fault (latched over-temperature, temperature warning, or a shorted current reference) replaces the whole captured word with ones.

Capture normally happens when the blanking input rises. The block also sequences a low-current "invisible" test. The test is armed by a non-zero test-current code while blanking is configured as an output enable. On the falling edge of blanking, a sink-enable output turns on for a programmable window of 17, 33, 65 or 129 oscillator cycles. The window ends early if blanking rises first. When the window ends, the holder captures with the test qualification. A separate source-enable output drives the leakage test current. The blanking input is synchronised into the oscillator domain with two flops before edge detection.

Top module: `led_status_capture`

## Requirements
- R1: While the select field is 00 the holder never changes. Codes 01, 10 and 11 select open, short and leakage results respectively.
- R2: Outside the invisible test, the holder captures on a synchronised rising edge of `blank_pin`. Open and short bits are kept only for channels whose `onoff` bit is 1, and leakage bits only for channels whose `onoff` bit is 0. Every other bit captures as 0.
- R3: The latched thermal error makes a select-01 capture all ones. The flag is set while `therm_err_in` is 1 and stays set after it returns to 0, until `lat_strobe` pulses.
- R4: A select-10 capture is all ones exactly while `warn_in` is 1, with no stickiness. A select-11 capture is all ones while `iref_short` is 1.
- R5: The invisible test is armed only when `idm_cur` is non-zero and `blk_mode` is 1. When armed, `idm_sink_en` rises three clocks after `blank_pin` falls. When not armed, it stays 0 and captures follow R2.
- R6: Once started, `idm_sink_en` stays high for 17, 33, 65 or 129 clocks for `idm_tim` codes 00, 01, 10 and 11. The holder captures when it drops. A rising edge of `blank_pin` after that does not capture again.
- R7: A rising `blank_pin` edge during the window ends it in the same cycle the edge is detected, and the holder captures then.
- R8: A test-window capture keeps open and short bits only for channels whose `onoff` bit is 0. A select-11 test capture is all zeros, or all ones when `iref_short` is 1.
- R9: `leak_src_en` is 1 only while the select field is 11, the synchronised blanking is low and the test is not armed.
- R10: After reset the holder is all zeros and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_pin | input | 1 | Asynchronous blanking input |
| lat_strobe | input | 1 | One-cycle latch pulse, clears the thermal error flag |
| onoff | input | 16 | Per-channel on-off data |
| sel | input | 2 | Status source select |
| idm_cur | input | 2 | Invisible test current code, 00 disables |
| idm_tim | input | 2 | Invisible test window code |
| blk_mode | input | 1 | 1 = blanking acts as output enable |
| open_cmp | input | 16 | Open-circuit comparator results |
| short_cmp | input | 16 | Short-circuit comparator results |
| leak_cmp | input | 16 | Leakage comparator results |
| therm_err_in | input | 1 | Over-temperature comparator |
| warn_in | input | 1 | Temperature warning comparator |
| iref_short | input | 1 | Current reference short detector |
| status | output | 16 | Status holder |
| idm_sink_en | output | 1 | Invisible test sink enable |
| leak_src_en | output | 1 | Leakage test source enable |

## Verification
The bench measures each of the four test windows to the exact cycle. A counter that is off by one, or a window code decoded wrongly, shows up as a sink enable dropping one cycle early or late. It cuts a window short with a blanking rise and checks that the capture comes from the test path. It also checks that the later rise does not overwrite the result. The thermal flag is driven high and then low. A design that does not hold the flag until the latch strobe would return real comparator data. The bench also checks that a pulse on the warning input does not stick. Random mixes of on-off data and comparator vectors expose inverted or swapped per-channel qualification, including the reversed rule during the test window.

// File: rtl/lsc_pkg.sv
// Shared definitions for the LED status capture sequencer.
// Assumes a 2-bit source select and qualification rules as in the brief.
package lsc_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_OPEN  = 2'b01,
        SRC_SHORT = 2'b10,
        SRC_LEAK  = 2'b11
    } src_sel_t;
endpackage

// File: rtl/lsc_blank_sync.sv
// Two-flop synchroniser for the blanking input plus edge detection.
// Assumes blank_in is asynchronous to clk; edges are single-cycle pulses.
module lsc_blank_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_in,
    output logic blank_s,
    output logic rise,
    output logic fall
);
    logic s1, s2, s_prev;

    // Synchronise and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s1     <= blank_in;
            s2     <= s1;
            s_prev <= s2;
        end
    end

    // Edge pulses from the synchronised level.
    always_comb begin
        blank_s = s2;
        rise    = s2 & ~s_prev;
        fall    = ~s2 & s_prev;
    end
endmodule

// File: rtl/lsc_idm_timer.sv
// Invisible test window timer: runs BASE_WIN<<code + 1 cycles after start,
// or ends early on stop. Assumes start and stop never coincide with an
// already-running window restart.
module lsc_idm_timer #(
    parameter int BASE_WIN = 16,
    parameter int CODE_W   = 2,
    localparam int MAX_WIN = (BASE_WIN << ((1 << CODE_W) - 1)) + 1,
    localparam int CNT_W   = $clog2(MAX_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [CODE_W-1:0] code,
    output logic              active,
    output logic              done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value of the selected window.
    always_comb begin
        last = CNT_W'((BASE_WIN << code) + 1 - 1);
        done = active & (stop | (cnt == last));
    end

    // Window state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (done) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsc_capture.sv
// Status holder with per-channel qualification and whole-word fault override.
// Also holds the sticky thermal error flag. Assumes comparator inputs are
// stable in the capture cycle.
module lsc_capture
    import lsc_pkg::*;
#(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_norm,
    input  logic          cap_test,
    input  logic          lat_strobe,
    input  logic [1:0]    sel,
    input  logic [CH-1:0] onoff,
    input  logic [CH-1:0] open_cmp,
    input  logic [CH-1:0] short_cmp,
    input  logic [CH-1:0] leak_cmp,
    input  logic          therm_err_in,
    input  logic          warn_in,
    input  logic          iref_short,
    output logic [CH-1:0] status
);
    logic          tef_q;
    logic [CH-1:0] drive_mask;
    logic [CH-1:0] next_word;

    // Sticky thermal error: set by the comparator, cleared by the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            tef_q <= 1'b0;
        else if (therm_err_in) tef_q <= 1'b1;
        else if (lat_strobe)   tef_q <= 1'b0;
    end

    // Pick the qualification mask and build the candidate word.
    always_comb begin
        drive_mask = cap_test ? ~onoff : onoff;
        unique case (src_sel_t'(sel))
            SRC_OPEN:  next_word = tef_q ? '1 : (open_cmp & drive_mask);
            SRC_SHORT: next_word = warn_in ? '1 : (short_cmp & drive_mask);
            SRC_LEAK:  next_word = iref_short ? '1 :
                                   (cap_test ? '0 : (leak_cmp & ~onoff));
            default:   next_word = status;
        endcase
    end

    // Holder update on either capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)                   status <= '0;
        else if (cap_norm || cap_test) status <= next_word;
    end
endmodule

// File: rtl/led_status_capture.sv
// Top of the LED fault status capture sequencer: synchronises blanking,
// runs the invisible test window and drives the status holder.
// Assumes all control fields are quasi-static around capture events.
module led_status_capture #(
    parameter int CH       = 16,
    parameter int BASE_WIN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank_pin,
    input  logic          lat_strobe,
    input  logic [CH-1:0] onoff,
    input  logic [1:0]    sel,
    input  logic [1:0]    idm_cur,
    input  logic [1:0]    idm_tim,
    input  logic          blk_mode,
    input  logic [CH-1:0] open_cmp,
    input  logic [CH-1:0] short_cmp,
    input  logic [CH-1:0] leak_cmp,
    input  logic          therm_err_in,
    input  logic          warn_in,
    input  logic          iref_short,
    output logic [CH-1:0] status,
    output logic          idm_sink_en,
    output logic          leak_src_en
);
    logic blank_s, b_rise, b_fall;
    logic idm_armed, win_active, win_done;
    logic cap_norm;

    lsc_blank_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_in (blank_pin),
        .blank_s  (blank_s),
        .rise     (b_rise),
        .fall     (b_fall)
    );

    // Test arming and the capture event outside the test.
    always_comb begin
        idm_armed   = (idm_cur != 2'b00) & blk_mode;
        cap_norm    = b_rise & ~idm_armed & ~win_active;
        idm_sink_en = win_active;
        leak_src_en = (sel == 2'b11) & ~blank_s & ~idm_armed;
    end

    lsc_idm_timer #(.BASE_WIN(BASE_WIN), .CODE_W(2)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (b_fall & idm_armed),
        .stop   (b_rise),
        .code   (idm_tim),
        .active (win_active),
        .done   (win_done)
    );

    lsc_capture #(.CH(CH)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_norm     (cap_norm),
        .cap_test     (win_done),
        .lat_strobe   (lat_strobe),
        .sel          (sel),
        .onoff        (onoff),
        .open_cmp     (open_cmp),
        .short_cmp    (short_cmp),
        .leak_cmp     (leak_cmp),
        .therm_err_in (therm_err_in),
        .warn_in      (warn_in),
        .iref_short   (iref_short),
        .status       (status)
    );
endmodule

// File: rtl/lsc_checker.sv
// Assertion checker for led_status_capture, attached by bind below.
module lsc_checker #(
    parameter int CH      = 16,
    parameter int MAX_WIN = 129
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CH-1:0] onoff,
    input logic [1:0]    sel,
    input logic [1:0]    idm_cur,
    input logic          blk_mode,
    input logic          iref_short,
    input logic [CH-1:0] status,
    input logic          idm_sink_en,
    input logic          leak_src_en
);
    logic [7:0] run_len;

    // Count consecutive cycles of sink enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !idm_sink_en) run_len <= '0;
        else if (run_len != 8'hFF)  run_len <= run_len + 1'b1;
    end

    a_r1_sel_none_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> $stable(status));

    a_r2_leak_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && $past(sel) == 2'b11 && !$past(iref_short))
        |-> ((status & $past(onoff)) == '0));

    a_r5_sink_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idm_sink_en) |-> ($past(blk_mode) && $past(idm_cur) != 2'b00));

    a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 8'(MAX_WIN));

    a_r9_leak_source: assert property (@(posedge clk) disable iff (!rst_n)
        leak_src_en |-> (sel == 2'b11 && !(blk_mode && idm_cur != 2'b00)));

    a_r10_reset_state: assert property (@(posedge clk)
        $past(!rst_n) |-> (status == '0 && !idm_sink_en));
endmodule

bind led_status_capture lsc_checker #(.CH(CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .onoff       (onoff),
    .sel         (sel),
    .idm_cur     (idm_cur),
    .blk_mode    (blk_mode),
    .iref_short  (iref_short),
    .status      (status),
    .idm_sink_en (idm_sink_en),
    .leak_src_en (leak_src_en)
);

// File: tb/sim_led_status_capture.sv
module sim_led_status_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blank_pin = 1'b0, lat_strobe = 1'b0;
    logic [15:0] onoff = '0, open_cmp = '0, short_cmp = '0, leak_cmp = '0;
    logic [1:0]  sel = '0, idm_cur = '0, idm_tim = '0;
    logic        blk_mode = 1'b0, therm_err_in = 1'b0, warn_in = 1'b0, iref_short = 1'b0;
    logic [15:0] status;
    logic        idm_sink_en, leak_src_en;
    int          n_chk = 0, n_bad = 0;
    logic        tef_m = 1'b0;
    logic [15:0] prev;

    always #10 clk = ~clk;

    led_status_capture u0 (.*);

    function automatic logic [15:0] exp_norm(input logic [1:0] s, input logic [15:0] p);
        case (s)
            2'b01:   return tef_m ? 16'hFFFF : (open_cmp & onoff);
            2'b10:   return warn_in ? 16'hFFFF : (short_cmp & onoff);
            2'b11:   return iref_short ? 16'hFFFF : (leak_cmp & ~onoff);
            default: return p;
        endcase
    endfunction

    function automatic logic [15:0] exp_test(input logic [1:0] s, input logic [15:0] p);
        case (s)
            2'b01:   return tef_m ? 16'hFFFF : (open_cmp & ~onoff);
            2'b10:   return warn_in ? 16'hFFFF : (short_cmp & ~onoff);
            2'b11:   return iref_short ? 16'hFFFF : 16'h0000;
            default: return p;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Blank low then high with the test disarmed; returns after capture.
    task automatic norm_capture(input string req);
        prev = status;
        blank_pin = 1'b0; cyc(5);
        blank_pin = 1'b1; cyc(4);
        chk(req, status, exp_norm(sel, prev));
    endtask

    // Full-length test window with the given code; blanking already high.
    task automatic test_window(input logic [1:0] code, input string req);
        int n;
        n = (16 << code) + 1;
        idm_tim = code; prev = status;
        blank_pin = 1'b0; cyc(2);
        chk(req, idm_sink_en, 1'b0);
        cyc(1);
        chk(req, idm_sink_en, 1'b1);
        cyc(n - 1);
        chk(req, idm_sink_en, 1'b1);
        cyc(1);
        chk(req, idm_sink_en, 1'b0);
        chk(req, status, exp_test(sel, prev));
        prev = status;
        blank_pin = 1'b1; cyc(5);
        chk("R6 no recapture", status, prev);
    endtask

    initial begin
        void'($urandom(32'd4242));
        blank_pin = 1'b1;
        cyc(3); rst_n = 1'b1; cyc(1);
        // R10 reset state
        chk("R10 status", status, 16'h0);
        chk("R10 sink", idm_sink_en, 1'b0);
        chk("R10 leak src", leak_src_en, 1'b0);
        cyc(5);

        // R1/R2 random normal captures
        for (int i = 0; i < 40; i++) begin
            onoff = 16'($urandom); open_cmp = 16'($urandom);
            short_cmp = 16'($urandom); leak_cmp = 16'($urandom);
            sel = 2'($urandom);
            idm_cur = 2'($urandom); blk_mode = (idm_cur == 2'b00) ? 1'($urandom) : 1'b0;
            norm_capture(sel == 2'b00 ? "R1 hold" : "R2 qualified capture");
        end

        // R1 select 00 leaves holder alone even with all faults set
        sel = 2'b01; onoff = 16'hFFFF; open_cmp = 16'h5A5A; norm_capture("R2 open");
        sel = 2'b00; open_cmp = 16'hFFFF; warn_in = 1'b1; iref_short = 1'b1;
        norm_capture("R1 select none");
        warn_in = 1'b0; iref_short = 1'b0;

        // R3 sticky thermal error
        sel = 2'b01; onoff = 16'h00FF; open_cmp = 16'h0F0F;
        therm_err_in = 1'b1; cyc(2); tef_m = 1'b1; therm_err_in = 1'b0; cyc(2);
        norm_capture("R3 thermal sticky");
        lat_strobe = 1'b1; cyc(1); lat_strobe = 1'b0; tef_m = 1'b0; cyc(1);
        norm_capture("R3 cleared by strobe");

        // R4 warning follows input, reference short
        sel = 2'b10; short_cmp = 16'h3C3C; warn_in = 1'b1;
        norm_capture("R4 warning ones");
        warn_in = 1'b0; norm_capture("R4 warning not sticky");
        sel = 2'b11; iref_short = 1'b1; norm_capture("R4 ref short ones");
        iref_short = 1'b0; leak_cmp = 16'hFFFF; norm_capture("R2 leak off channels");

        // R9 leak source enable
        blank_pin = 1'b0; cyc(4);
        chk("R9 leak src on", leak_src_en, 1'b1);
        sel = 2'b10; cyc(1);
        chk("R9 leak src sel", leak_src_en, 1'b0);
        sel = 2'b11; blk_mode = 1'b1; idm_cur = 2'b01; cyc(1);
        chk("R9 leak src armed", leak_src_en, 1'b0);
        blank_pin = 1'b1; cyc(5);

        // R5 not armed when blanking mode is 0
        blk_mode = 1'b0; idm_cur = 2'b10; sel = 2'b01; tef_m = 1'b0;
        onoff = 16'hF0F0; open_cmp = 16'hFFFF;
        blank_pin = 1'b0; cyc(6);
        chk("R5 unarmed no sink", idm_sink_en, 1'b0);
        prev = status; blank_pin = 1'b1; cyc(4);
        chk("R5 unarmed normal capture", status, exp_norm(sel, prev));

        // R6/R8 each window code
        blk_mode = 1'b1; idm_cur = 2'b11;
        for (int c = 0; c < 4; c++) begin
            onoff = 16'($urandom); open_cmp = 16'($urandom); short_cmp = 16'($urandom);
            sel = (c % 2 == 0) ? 2'b01 : 2'b10;
            test_window(2'(c), "R6 window length R8 qualification");
        end
        sel = 2'b11; leak_cmp = 16'hFFFF; onoff = 16'h0000;
        test_window(2'b00, "R8 leak during test");

        // R7 early end by blanking rise
        sel = 2'b10; onoff = 16'h1234; short_cmp = 16'hFFFF; idm_tim = 2'b11;
        prev = status;
        blank_pin = 1'b0; cyc(8);
        chk("R7 sink running", idm_sink_en, 1'b1);
        blank_pin = 1'b1; cyc(2);
        chk("R7 still running", idm_sink_en, 1'b1);
        cyc(1);
        chk("R7 stopped by rise", idm_sink_en, 1'b0);
        chk("R7 test capture", status, exp_test(sel, prev));

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule